// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger

This block watches the program counter stream and the data bus of a processor and produces a trigger pulse when a two-step breakpoint sequence completes. There are three kinds of match source. The first is a PC match, formed from four comparators, where comparator 0 uses a bit mask. The other two are address/data pairs, and each pair checks an address range, qualifies it by access attributes, and can optionally require a masked data compare as well.

Software programs the comparators and a control word through a simple write port. The control word selects which source arms the sequence (level one). The two remaining sources then become the level-two candidates. After level one has matched, a level-two match in a later cycle fires a single-cycle trigger and sets a sticky status flag. The sequence then returns to idle. A soft-reset bit in the control word clears the sequence and both status flags.

Top module: `bpt_trigger_unit`

## Requirements
- R1: PC comparator 0 (value at register 2) matches when `pc_valid_i` is 1 and the PC equals the value on every bit whose mask bit (register 1) is 0. A mask bit of 1 excludes that bit. A PC with `pc_valid_i` low never matches.
- R2: PC comparators 1..3 (registers 3..5) compare all bits with no mask. Comparator k takes part only when control bit 8+k is 1. The PC source is the OR of all enabled comparators.
- R3: A pair's address hit needs `bus_valid_i` and lo <= address <= hi, with both bounds inclusive. Pair 0 uses registers 6 (lo) and 7 (hi); pair 1 uses registers 11 and 12. Control bit 6 (pair 0) or bit 7 (pair 1) inverts the range test.
- R4: The attribute register (8 or 13) qualifies the hit. Bit 1 enables a check that `bus_write_i` equals bit 0. Bit 4 enables a check that `bus_size_i` equals bits 3:2. Bit 6 enables a check that `bus_super_i` equals bit 5.
- R5: When control bit 2 (pair 0) or bit 3 (pair 1) is 1, the pair also needs the data to equal its data register (9 or 14) on every bit whose data mask bit (10 or 15) is 0. When the bit is 0, the data is ignored.
- R6: Control bits 1:0 select level one: 0 selects PC, 1 selects pair 0, 2 selects pair 1, and 3 disables the sequence. Level two is the OR of the two sources not selected.
- R7: A level-two match in the same cycle as the level-one match does not fire. Level two is only considered in cycles after the arming edge.
- R8: `trig_o` is high for exactly one cycle, in the cycle after the clock edge that samples the level-two match. The sequence then returns to idle, and further level-two matches do not fire.
- R9: `armed_o` becomes 1 on the edge that samples a level-one match. `fired_o` becomes 1 together with `trig_o`. Both flags hold their value until a reset.
- R10: Writing register 0 with bit 5 set clears the sequence, `armed_o`, `fired_o` and `trig_o` on that edge. The other control fields in the same write take effect.
- R11: After `rst_ni` is low, all outputs are 0. The sequence arms only when control bit 4 (enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| pc_valid_i | input | 1 | PC sample valid |
| pc_i | input | 32 | Program counter |
| bus_valid_i | input | 1 | Bus access valid |
| bus_addr_i | input | 32 | Bus address |
| bus_data_i | input | 32 | Bus data |
| bus_write_i | input | 1 | 1 = write access |
| bus_size_i | input | 2 | Access size code |
| bus_super_i | input | 1 | 1 = supervisor access |
| trig_o | output | 1 | Single-cycle trigger pulse |
| armed_o | output | 1 | Sticky: level one seen |
| fired_o | output | 1 | Sticky: trigger fired |

## Verification
The bench probes the exact range bounds and the addresses one step outside them. A design that used strict comparisons would miss the bound accesses, and one with an off-by-one error would accept the outside addresses. It drives level-one and level-two matches in the same cycle, where a design that evaluated both levels together would fire early. It re-presents the level-one source while the sequence is armed, where a design with the wrong level-two set would fire. Further checks cover masked data and PC bits, the inverted range, triggers after the sequence has fired, and a soft reset issued while armed, which must stop a later level-two match from firing.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int CTRL_SEL_LSB  = 0;
  localparam int CTRL_DQ0      = 2;
  localparam int CTRL_DQ1      = 3;
  localparam int CTRL_EN       = 4;
  localparam int CTRL_SRST     = 5;
  localparam int CTRL_INV0     = 6;
  localparam int CTRL_INV1     = 7;
  localparam int CTRL_PCEN_LSB = 8;

  localparam int ATTR_W      = 7;
  localparam int ATTR_RW_VAL = 0;
  localparam int ATTR_RW_EN  = 1;
  localparam int ATTR_SZ_LSB = 2;
  localparam int ATTR_SZ_EN  = 4;
  localparam int ATTR_SU_VAL = 5;
  localparam int ATTR_SU_EN  = 6;

  localparam int NPAIR    = 2;
  localparam int PAIR_NREG = 5;

  typedef enum logic [1:0] {
    SEL_PC  = 2'd0,
    SEL_AP0 = 2'd1,
    SEL_AP1 = 2'd2,
    SEL_OFF = 2'd3
  } lvl_sel_e;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_ARMED = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       write;
    logic [1:0] size;
    logic       priv;
  } bus_attr_t;
endpackage

// File: rtl/bpt_pc_cmp.sv
module bpt_pc_cmp #(
  parameter int NPC = 4,
  parameter int AW  = 32
) (
  input  logic                    pc_valid_i,
  input  logic [AW-1:0]           pc_i,
  input  logic [NPC-1:0]          en_i,
  input  logic [NPC-1:0][AW-1:0]  val_i,
  input  logic [AW-1:0]           mask_i,
  output logic                    hit_o
);
  logic [NPC-1:0] cmp_hit;

  for (genvar i = 0; i < NPC; i++) begin : g_cmp
    if (i == 0) begin : g_masked
      assign cmp_hit[i] = en_i[i] && (((pc_i ^ val_i[i]) & ~mask_i) == '0);
    end else begin : g_full
      assign cmp_hit[i] = en_i[i] && (pc_i == val_i[i]);
    end
  end

  assign hit_o = pc_valid_i && (|cmp_hit);
endmodule

// File: rtl/bpt_addr_unit.sv
module bpt_addr_unit
  import bpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  bus_attr_t         attr_i,
  input  logic [AW-1:0]     lo_i,
  input  logic [AW-1:0]     hi_i,
  input  logic [ATTR_W-1:0] attr_cfg_i,
  input  logic [DW-1:0]     dval_i,
  input  logic [DW-1:0]     dmask_i,
  input  logic              inv_i,
  input  logic              dq_i,
  output logic              hit_o
);
  logic in_rng, rng_ok, rw_ok, sz_ok, su_ok, data_ok;

  assign in_rng = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign rng_ok = inv_i ? !in_rng : in_rng;

  assign rw_ok = !attr_cfg_i[ATTR_RW_EN] || (attr_i.write == attr_cfg_i[ATTR_RW_VAL]);
  assign sz_ok = !attr_cfg_i[ATTR_SZ_EN] ||
                 (attr_i.size == attr_cfg_i[ATTR_SZ_LSB +: 2]);
  assign su_ok = !attr_cfg_i[ATTR_SU_EN] || (attr_i.priv == attr_cfg_i[ATTR_SU_VAL]);

  // data compare only narrows the address hit
  assign data_ok = !dq_i || (((data_i ^ dval_i) & ~dmask_i) == '0);

  assign hit_o = bus_valid_i && rng_ok && rw_ok && sz_ok && su_ok && data_ok;
endmodule

// File: rtl/bpt_seq.sv
module bpt_seq
  import bpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  lvl_sel_e         sel_i,
  input  logic             srst_i,
  input  logic             pc_hit_i,
  input  logic [NPAIR-1:0] ap_hit_i,
  output logic             trig_o,
  output logic             armed_o,
  output logic             fired_o,
  output logic             seq_armed_o
);
  seq_state_e state_q;
  logic lvl1_hit, lvl2_hit;

  always_comb begin
    lvl1_hit = 1'b0;
    lvl2_hit = 1'b0;
    unique case (sel_i)
      SEL_PC:  begin lvl1_hit = pc_hit_i;    lvl2_hit = ap_hit_i[0] || ap_hit_i[1]; end
      SEL_AP0: begin lvl1_hit = ap_hit_i[0]; lvl2_hit = pc_hit_i || ap_hit_i[1];    end
      SEL_AP1: begin lvl1_hit = ap_hit_i[1]; lvl2_hit = pc_hit_i || ap_hit_i[0];    end
      default: begin lvl1_hit = 1'b0;        lvl2_hit = 1'b0;                       end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      trig_o  <= 1'b0;
      armed_o <= 1'b0;
      fired_o <= 1'b0;
    end else if (srst_i) begin
      state_q <= SQ_IDLE;
      trig_o  <= 1'b0;
      armed_o <= 1'b0;
      fired_o <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (en_i && lvl1_hit) begin
            state_q <= SQ_ARMED;
            armed_o <= 1'b1;
          end
        end
        SQ_ARMED: begin
          if (!en_i) begin
            state_q <= SQ_IDLE;
          end else if (lvl2_hit) begin
            state_q <= SQ_IDLE;
            trig_o  <= 1'b1;
            fired_o <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign seq_armed_o = (state_q == SQ_ARMED);
endmodule

// File: rtl/bpt_trigger_unit.sv
module bpt_trigger_unit
  import bpt_pkg::*;
#(
  parameter int NPC = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 32,
  localparam int PcBase   = 2,
  localparam int PairBase = PcBase + NPC,
  localparam int NReg     = PairBase + NPAIR * PAIR_NREG,
  localparam int AddrW    = $clog2(NReg)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [AddrW-1:0] cfg_addr_i,
  input  logic [CW-1:0]    cfg_wdata_i,
  input  logic             pc_valid_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             bus_valid_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_data_i,
  input  logic             bus_write_i,
  input  logic [1:0]       bus_size_i,
  input  logic             bus_super_i,
  output logic             trig_o,
  output logic             armed_o,
  output logic             fired_o
);
  lvl_sel_e                sel_q;
  logic                    en_q;
  logic [NPAIR-1:0]        dq_q, inv_q;
  logic [NPC-1:0]          pcen_q;
  logic [AW-1:0]           pc_mask_q;
  logic [NPC-1:0][AW-1:0]  pc_val_q;
  logic [AW-1:0]           lo_q    [NPAIR];
  logic [AW-1:0]           hi_q    [NPAIR];
  logic [ATTR_W-1:0]       attr_q  [NPAIR];
  logic [DW-1:0]           dval_q  [NPAIR];
  logic [DW-1:0]           dmask_q [NPAIR];

  logic             ctrl_wr, srst;
  logic             pc_hit;
  logic [NPAIR-1:0] ap_hit;
  logic             seq_armed;
  bus_attr_t        bus_attr;

  assign ctrl_wr = cfg_we_i && (cfg_addr_i == AddrW'(0));
  assign srst    = ctrl_wr && cfg_wdata_i[CTRL_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SEL_PC;
      en_q      <= 1'b0;
      dq_q      <= '0;
      inv_q     <= '0;
      pcen_q    <= '0;
      pc_mask_q <= '0;
      pc_val_q  <= '0;
      for (int j = 0; j < NPAIR; j++) begin
        lo_q[j]    <= '0;
        hi_q[j]    <= '0;
        attr_q[j]  <= '0;
        dval_q[j]  <= '0;
        dmask_q[j] <= '0;
      end
    end else if (cfg_we_i) begin
      if (ctrl_wr) begin
        sel_q    <= lvl_sel_e'(cfg_wdata_i[CTRL_SEL_LSB +: 2]);
        en_q     <= cfg_wdata_i[CTRL_EN];
        dq_q     <= {cfg_wdata_i[CTRL_DQ1], cfg_wdata_i[CTRL_DQ0]};
        inv_q    <= {cfg_wdata_i[CTRL_INV1], cfg_wdata_i[CTRL_INV0]};
        pcen_q   <= cfg_wdata_i[CTRL_PCEN_LSB +: NPC];
      end
      if (cfg_addr_i == AddrW'(1)) pc_mask_q <= cfg_wdata_i[AW-1:0];
      for (int i = 0; i < NPC; i++) begin
        if (cfg_addr_i == AddrW'(PcBase + i)) pc_val_q[i] <= cfg_wdata_i[AW-1:0];
      end
      for (int j = 0; j < NPAIR; j++) begin
        if (cfg_addr_i == AddrW'(PairBase + j*PAIR_NREG + 0)) lo_q[j]    <= cfg_wdata_i[AW-1:0];
        if (cfg_addr_i == AddrW'(PairBase + j*PAIR_NREG + 1)) hi_q[j]    <= cfg_wdata_i[AW-1:0];
        if (cfg_addr_i == AddrW'(PairBase + j*PAIR_NREG + 2)) attr_q[j]  <= cfg_wdata_i[ATTR_W-1:0];
        if (cfg_addr_i == AddrW'(PairBase + j*PAIR_NREG + 3)) dval_q[j]  <= cfg_wdata_i[DW-1:0];
        if (cfg_addr_i == AddrW'(PairBase + j*PAIR_NREG + 4)) dmask_q[j] <= cfg_wdata_i[DW-1:0];
      end
    end
  end

  bpt_pc_cmp #(.NPC(NPC), .AW(AW)) i_pc_cmp (
    .pc_valid_i (pc_valid_i),
    .pc_i       (pc_i),
    .en_i       (pcen_q),
    .val_i      (pc_val_q),
    .mask_i     (pc_mask_q),
    .hit_o      (pc_hit)
  );

  assign bus_attr = '{write: bus_write_i, size: bus_size_i, priv: bus_super_i};

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    bpt_addr_unit #(.AW(AW), .DW(DW)) i_addr_unit (
      .bus_valid_i (bus_valid_i),
      .addr_i      (bus_addr_i),
      .data_i      (bus_data_i),
      .attr_i      (bus_attr),
      .lo_i        (lo_q[j]),
      .hi_i        (hi_q[j]),
      .attr_cfg_i  (attr_q[j]),
      .dval_i      (dval_q[j]),
      .dmask_i     (dmask_q[j]),
      .inv_i       (inv_q[j]),
      .dq_i        (dq_q[j]),
      .hit_o       (ap_hit[j])
    );
  end

  bpt_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .sel_i       (sel_q),
    .srst_i      (srst),
    .pc_hit_i    (pc_hit),
    .ap_hit_i    (ap_hit),
    .trig_o      (trig_o),
    .armed_o     (armed_o),
    .fired_o     (fired_o),
    .seq_armed_o (seq_armed)
  );
endmodule

// File: rtl/bpt_trigger_unit_chk.sv
module bpt_trigger_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_wr_i,
  input logic srst_bit_i,
  input logic seq_armed_i,
  input logic trig_o,
  input logic armed_o,
  input logic fired_o
);
  logic srst;
  assign srst = ctrl_wr_i && srst_bit_i;

  a_r8_trig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r7_trig_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(seq_armed_i));

  a_r9_trig_sets_fired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> fired_o);

  a_r9_fired_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_o && !srst) |=> fired_o);

  a_r9_armed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !srst) |=> armed_o);

  a_r6_fired_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_o |-> armed_o);

  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (!armed_o && !fired_o && !trig_o));
endmodule

bind bpt_trigger_unit bpt_trigger_unit_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (cfg_we_i && (cfg_addr_i == '0)),
  .srst_bit_i  (cfg_wdata_i[5]),
  .seq_armed_i (seq_armed),
  .trig_o      (trig_o),
  .armed_o     (armed_o),
  .fired_o     (fired_o)
);

// File: tb/test_bpt_trigger_unit.sv
module test_bpt_trigger_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        pc_valid_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        bus_valid_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic [31:0] bus_data_i = '0;
  logic        bus_write_i = 1'b0;
  logic [1:0]  bus_size_i = '0;
  logic        bus_super_i = 1'b0;
  logic        trig_o, armed_o, fired_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bpt_trigger_unit i_bpt_trigger_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .pc_valid_i(pc_valid_i), .pc_i(pc_i),
    .bus_valid_i(bus_valid_i), .bus_addr_i(bus_addr_i), .bus_data_i(bus_data_i),
    .bus_write_i(bus_write_i), .bus_size_i(bus_size_i), .bus_super_i(bus_super_i),
    .trig_o(trig_o), .armed_o(armed_o), .fired_o(fired_o)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic        wr;
    logic [1:0]  sz;
    logic        su;
    logic        exp;
  } vec_t;

  // pair 0: range 0x1000..0x10FF, write, size 2, data 0xCAFExxxx
  localparam vec_t VEC [10] = '{
    '{32'h0000_1000, 32'hCAFE_1234, 1'b1, 2'd2, 1'b0, 1'b1},
    '{32'h0000_10FF, 32'hCAFE_0000, 1'b1, 2'd2, 1'b0, 1'b1},
    '{32'h0000_0FFF, 32'hCAFE_0000, 1'b1, 2'd2, 1'b0, 1'b0},
    '{32'h0000_1100, 32'hCAFE_0000, 1'b1, 2'd2, 1'b0, 1'b0},
    '{32'h0000_1050, 32'hCAFE_0000, 1'b0, 2'd2, 1'b0, 1'b0},
    '{32'h0000_1050, 32'hCAFE_0000, 1'b1, 2'd1, 1'b0, 1'b0},
    '{32'h0000_1050, 32'hCAFE_0000, 1'b1, 2'd2, 1'b1, 1'b1},
    '{32'h0000_1050, 32'hCAFF_0000, 1'b1, 2'd2, 1'b0, 1'b0},
    '{32'h0000_1050, 32'hCAFE_FFFF, 1'b1, 2'd2, 1'b0, 1'b1},
    '{32'h0000_1050, 32'h0AFE_0000, 1'b1, 2'd2, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic cyc(input logic pv, input logic [31:0] p, input logic bv,
                     input logic [31:0] a, input logic [31:0] d,
                     input logic w, input logic [1:0] sz, input logic su);
    pc_valid_i = pv; pc_i = p; bus_valid_i = bv; bus_addr_i = a; bus_data_i = d;
    bus_write_i = w; bus_size_i = sz; bus_super_i = su;
    @(posedge clk); @(negedge clk);
    pc_valid_i = 1'b0; bus_valid_i = 1'b0;
  endtask

  task automatic pc_cyc(input logic [31:0] p);
    cyc(1'b1, p, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic bus_cyc(input logic [31:0] a, input logic [31:0] d);
    cyc(1'b0, '0, 1'b1, a, d, 1'b1, 2'd2, 1'b0);
  endtask

  task automatic idle_cyc();
    cyc(1'b0, '0, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset trig", trig_o, 0);
    chk("R11 reset armed", armed_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 reset fired", fired_o, 0);

    wr(4'd1, 32'h0000_000F);   // pc mask
    wr(4'd2, 32'h0000_2000);   // pc0
    wr(4'd3, 32'h0000_4004);   // pc1
    wr(4'd6, 32'h0000_1000);
    wr(4'd7, 32'h0000_10FF);
    wr(4'd8, 32'h0000_001B);   // write, size 2
    wr(4'd9, 32'hCAFE_0000);
    wr(4'd10, 32'h0000_FFFF);
    wr(4'd11, 32'h0000_3000);
    wr(4'd12, 32'h0000_3000);

    // table: pair 0 as level one, data qualify on (R3 R4 R5)
    foreach (VEC[i]) begin
      wr(4'd0, 32'h15 | 32'h20);
      cyc(1'b0, '0, 1'b1, VEC[i].a, VEC[i].d, VEC[i].wr, VEC[i].sz, VEC[i].su);
      chk($sformatf("R3 R4 R5 vector %0d armed", i), armed_o, VEC[i].exp);
      chk($sformatf("R7 vector %0d no trig", i), trig_o, 0);
    end

    // PC level one -> pair 1 level two
    wr(4'd0, 32'h110 | 32'h20);
    pc_cyc(32'h0000_2010);
    chk("R1 mask keeps upper bits", armed_o, 0);
    cyc(1'b0, 32'h0000_200A, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
    chk("R1 pc_valid low", armed_o, 0);
    pc_cyc(32'h0000_200A);
    chk("R1 masked pc match arms", armed_o, 1);
    chk("R9 fired not yet", fired_o, 0);
    bus_cyc(32'h0000_3000, 32'h0);
    chk("R8 trig pulse", trig_o, 1);
    chk("R9 fired set", fired_o, 1);
    idle_cyc();
    chk("R8 trig one cycle", trig_o, 0);
    chk("R9 armed sticky", armed_o, 1);
    bus_cyc(32'h0000_3000, 32'h0);
    chk("R8 idle after fire", trig_o, 0);
    chk("R9 fired sticky", fired_o, 1);

    // same-cycle level one and two
    wr(4'd0, 32'h111 | 32'h20);
    chk("R10 srst clears fired", fired_o, 0);
    chk("R10 srst clears armed", armed_o, 0);
    cyc(1'b1, 32'h0000_2000, 1'b1, 32'h0000_1000, 32'h0, 1'b1, 2'd2, 1'b0);
    chk("R7 armed on same cycle", armed_o, 1);
    chk("R7 no trig same cycle", trig_o, 0);
    idle_cyc();
    chk("R7 no late trig", trig_o, 0);
    bus_cyc(32'h0000_1000, 32'h0);
    chk("R6 level one source not in level two", trig_o, 0);
    pc_cyc(32'h0000_2000);
    chk("R6 pc level two fires", trig_o, 1);

    // full PC compare on comparator 1
    wr(4'd0, 32'h210 | 32'h20);
    pc_cyc(32'h0000_4005);
    chk("R2 full compare ignores mask", armed_o, 0);
    pc_cyc(32'h0000_2000);
    chk("R2 disabled comparator 0", armed_o, 0);
    pc_cyc(32'h0000_4004);
    chk("R2 comparator 1 match", armed_o, 1);

    // inverted range
    wr(4'd0, 32'h51 | 32'h20);
    bus_cyc(32'h0000_1050, 32'h0);
    chk("R3 inverted inside", armed_o, 0);
    bus_cyc(32'h0000_2000, 32'h0);
    chk("R3 inverted outside", armed_o, 1);

    // data qualify off
    wr(4'd0, 32'h11 | 32'h20);
    bus_cyc(32'h0000_1000, 32'h0);
    chk("R5 data ignored", armed_o, 1);

    // enable / off select
    wr(4'd0, 32'h01 | 32'h20);
    bus_cyc(32'h0000_1000, 32'hCAFE_0000);
    chk("R11 disabled", armed_o, 0);
    wr(4'd0, 32'h13 | 32'h20);
    bus_cyc(32'h0000_1000, 32'hCAFE_0000);
    chk("R6 select 3 off", armed_o, 0);

    // pair 1 level one -> PC level two, soft reset mid-sequence
    wr(4'd0, 32'h112 | 32'h20);
    bus_cyc(32'h0000_3000, 32'h0);
    chk("R6 pair1 arms", armed_o, 1);
    pc_cyc(32'h0000_2003);
    chk("R6 pair1 then pc fires", trig_o, 1);
    wr(4'd0, 32'h112 | 32'h20);
    bus_cyc(32'h0000_3000, 32'h0);
    chk("R6 re-arm", armed_o, 1);
    wr(4'd0, 32'h112 | 32'h20);
    chk("R10 srst clears armed mid", armed_o, 0);
    pc_cyc(32'h0000_2003);
    chk("R10 no trig after srst", trig_o, 0);
    chk("R10 fired stays clear", fired_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule